// File: doc/BRIEF.md
# Prefix-Coded Opcode Length Decoder

This block turns a byte stream into opcode numbers of variable length. The stream arrives one byte per cycle under a valid/ready handshake. The count of leading one-bits in the first byte of each opcode sets its length, from one to five bytes. Zero ones gives one byte, and runs of two, four, six or eight ones give two, three, four or five bytes. The payload bits left in the first byte are joined, most significant first, with every later byte to form a zero-extended 32-bit number.

When the last byte of an opcode has been taken, the block holds the number, its length and a one-cycle done pulse for one cycle. During that cycle ready is low. It then waits for the first byte of the next opcode. An encoding written longer than its value needs is still reported in full, with an overlong flag beside done. A flush input abandons an opcode whose bytes have only partly arrived and reports a truncation pulse. A synchronous reset returns the block to waiting for a first byte.

Top module: `prefix_opcode_decoder`

## Requirements
- R1: While and after a synchronous reset, in_ready is 1 and out_done, out_overlong and out_trunc are 0. Any partial opcode is dropped, and the next accepted byte is treated as a first byte.
- R2: A first byte whose bits [7:6] are not 11 forms a one-byte opcode. Its value is the byte itself and its length is 1. out_done rises in the cycle after that byte is accepted.
- R3: A first byte with bits [7:6]=11 and bits [5:4] not 11 forms a two-byte opcode of value {b1[5:0], b2} and length 2.
- R4: A first byte with bits [7:4]=1111 and bits [3:2] not 11 forms a three-byte opcode of value {b1[3:0], b2, b3} and length 3.
- R5: A first byte with bits [7:2]=111111 and bits [1:0] not 11 forms a four-byte opcode of value {b1[1:0], b2, b3, b4} and length 4.
- R6: A first byte of 0xFF forms a five-byte opcode of value {b2, b3, b4, b5} and length 5.
- R7: out_done is high for exactly one cycle per opcode, and in_ready is low in that cycle. A byte offered in that cycle is not consumed, and it becomes the first byte of the next opcode once ready returns.
- R8: out_overlong is high together with out_done when the value is below the smallest value that needs this length. Those limits are 192 for length 2, 12288 for length 3, 786432 for length 4 and 50331648 for length 5. A one-byte opcode is never overlong. The value and length are still reported.
- R9: A flush while an opcode is partly received discards it. out_trunc is then high for one cycle, in the cycle after the flush, with no done. The next accepted byte starts a new opcode. A flush while waiting for a first byte has no effect.
- R10: Cycles with in_valid low are ignored, whatever in_byte holds, so gaps may fall between any two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_byte holds a stream byte |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| flush | input | 1 | Abandon a partly received opcode |
| out_done | output | 1 | One-cycle pulse: result fields are valid |
| out_value | output | 32 | Decoded opcode number, zero-extended |
| out_len | output | 3 | Opcode length in bytes, 1 to 5 |
| out_overlong | output | 1 | Result used a longer form than needed |
| out_trunc | output | 1 | One-cycle pulse: a partial opcode was dropped |

## Verification
The hardest case to reach is a byte that arrives during the one cycle when the result is shown and ready is low. That byte must neither be lost nor taken early. The driver keeps in_valid high and sends opcodes back to back, so each new first byte sits on the bus during the result cycle. A wrong value or length on the next opcode reveals any slip. Overlong values are produced just below and at each length limit. Flushes are placed after one or more bytes of a long opcode, and also while the block waits for a first byte.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned MAX_LEN = 5;
    localparam int unsigned VAL_W   = 32;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
    localparam int unsigned RUNS    = MAX_LEN - 1;

    typedef enum logic [1:0] {
        ST_FIRST   = 2'd0,
        ST_GATHER  = 2'd1,
        ST_PRESENT = 2'd2
    } opdec_state_e;

    typedef struct packed {
        opdec_state_e      state;
        logic [LEN_W-1:0]  left;
        logic [LEN_W-1:0]  len;
        logic [VAL_W-1:0]  acc;
        logic              done;
        logic              ovl;
        logic              trunc;
    } opdec_reg_t;

    // Smallest value that cannot be written with fewer than n bytes.
    // A form of k bytes carries 6k+2 payload bits whose top pair is never 11,
    // so it spans 3 * 2^(6k) values.
    function automatic logic [VAL_W-1:0] min_for_len(input int unsigned n);
        logic [VAL_W-1:0] r;
        if (n <= 1) r = '0;
        else        r = VAL_W'(3) << (6 * (n - 1));
        return r;
    endfunction

endpackage

// File: rtl/opdec_lead.sv
module opdec_lead
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] first_byte,
    output logic [LEN_W-1:0]  lead_len,
    output logic [BYTE_W-1:0] lead_payload
);

    logic [RUNS-1:0] run;

    // run[g] is set when the top 2*(g+1) bits are all ones; the runs nest.
    generate
        for (genvar g = 0; g < RUNS; g++) begin : g_run
            assign run[g] = &first_byte[BYTE_W-1 -: 2*(g+1)];
        end
    endgenerate

    logic [BYTE_W-1:0] keep_mask;

    always_comb begin
        lead_len     = LEN_W'(1 + $countones(run));
        keep_mask    = {BYTE_W{1'b1}} >> (2 * (int'(lead_len) - 1));
        lead_payload = first_byte & keep_mask;
    end

endmodule

// File: rtl/opdec_range.sv
module opdec_range
    import opdec_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  logic [VAL_W-1:0] value,
    output logic             overlong
);

    logic [VAL_W-1:0] limit [MAX_LEN+1];

    generate
        for (genvar n = 0; n <= MAX_LEN; n++) begin : g_limit
            assign limit[n] = min_for_len(n);
        end
    endgenerate

    always_comb begin
        overlong = 1'b0;
        if (int'(len) >= 2 && int'(len) <= MAX_LEN)
            overlong = (value < limit[len]);
    end

endmodule

// File: rtl/prefix_opcode_decoder.sv
module prefix_opcode_decoder
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              flush,
    output logic              out_done,
    output logic [VAL_W-1:0]  out_value,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_overlong,
    output logic              out_trunc
);

    localparam opdec_reg_t REG_RESET = '{
        state: ST_FIRST,
        left:  '0,
        len:   '0,
        acc:   '0,
        done:  1'b0,
        ovl:   1'b0,
        trunc: 1'b0
    };

    opdec_reg_t r_q, r_d;

    logic [LEN_W-1:0]  lead_len;
    logic [BYTE_W-1:0] lead_payload;
    logic [VAL_W-1:0]  acc_app;
    logic              app_ovl;
    logic              take;

    opdec_lead u_lead (
        .first_byte   (in_byte),
        .lead_len     (lead_len),
        .lead_payload (lead_payload)
    );

    assign acc_app = {r_q.acc[VAL_W-BYTE_W-1:0], in_byte};

    opdec_range u_range (
        .len      (r_q.len),
        .value    (acc_app),
        .overlong (app_ovl)
    );

    assign in_ready = (r_q.state != ST_PRESENT);
    assign take     = in_valid && in_ready;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.ovl   = 1'b0;
        r_d.trunc = 1'b0;
        unique case (r_q.state)
            ST_FIRST: begin
                if (take) begin
                    r_d.len = lead_len;
                    r_d.acc = VAL_W'(lead_payload);
                    if (lead_len == LEN_W'(1)) begin
                        r_d.state = ST_PRESENT;
                        r_d.done  = 1'b1;
                        r_d.left  = '0;
                    end else begin
                        r_d.state = ST_GATHER;
                        r_d.left  = lead_len - LEN_W'(1);
                    end
                end
            end
            ST_GATHER: begin
                if (flush) begin
                    r_d.state = ST_FIRST;
                    r_d.trunc = 1'b1;
                    r_d.left  = '0;
                    r_d.acc   = '0;
                end else if (take) begin
                    r_d.acc  = acc_app;
                    r_d.left = r_q.left - LEN_W'(1);
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.state = ST_PRESENT;
                        r_d.done  = 1'b1;
                        r_d.ovl   = app_ovl;
                    end
                end
            end
            ST_PRESENT: begin
                r_d.state = ST_FIRST;
            end
            default: begin
                r_d = REG_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= REG_RESET;
        else     r_q <= r_d;
    end

    assign out_done     = r_q.done;
    assign out_value    = r_q.acc;
    assign out_len      = r_q.len;
    assign out_overlong = r_q.ovl;
    assign out_trunc    = r_q.trunc;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_done && !out_trunc && !out_overlong)); // R1

    AST_SHORT_VALUE: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_len == LEN_W'(1)) |-> (out_value < VAL_W'(192))); // R2

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_len >= LEN_W'(1) && int'(out_len) <= MAX_LEN)); // R6

    AST_DONE_HOLDS_READY: assert property (@(posedge clk) disable iff (rst)
        out_done |-> !in_ready); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done); // R7

    AST_OVL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        out_overlong |-> (out_done && out_len != LEN_W'(1))); // R8

    AST_TRUNC_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        out_trunc |-> ($past(flush) && !out_done && in_ready)); // R9

endmodule

// File: tb/test_prefix_opcode_decoder.sv
module test_prefix_opcode_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        flush = 1'b0;
    logic        out_done;
    logic [31:0] out_value;
    logic [2:0]  out_len;
    logic        out_overlong;
    logic        out_trunc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct packed {
        logic [31:0] v;
        logic [2:0]  len;
        logic        ovl;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    prefix_opcode_decoder i_prefix_opcode_decoder (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_ready     (in_ready),
        .flush        (flush),
        .out_done     (out_done),
        .out_value    (out_value),
        .out_len      (out_len),
        .out_overlong (out_overlong),
        .out_trunc    (out_trunc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic string len_req(input int n);
        case (n)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (!rst && out_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected done", 32'(out_value), 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(out_value == e.v, len_req(int'(e.len)), "value", out_value, e.v);
                chk(out_len == e.len, len_req(int'(e.len)), "length", 32'(out_len), 32'(e.len));
                chk(out_overlong == e.ovl, "R8", "overlong", 32'(out_overlong), 32'(e.ovl));
                chk(in_ready == 1'b0, "R7", "ready during done", 32'(in_ready), 32'h0);
                chk(out_trunc == 1'b0, "R9", "trunc with done", 32'(out_trunc), 32'h0);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Called at a negedge; returns at the negedge after the byte was taken.
    task automatic send_byte(input logic [7:0] b, input bit gap);
        if (gap) begin
            in_valid = 1'b0;
            in_byte  = 8'hFF;            // R10 garbage while not valid
            @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] limit_for(input int n);
        case (n)
            2: return 32'd192;
            3: return 32'd12288;
            4: return 32'd786432;
            5: return 32'd50331648;
            default: return 32'd0;
        endcase
    endfunction

    task automatic send_op(input int n, input logic [31:0] v, input bit gap);
        logic [7:0] b [5];
        exp_t e;
        case (n)
            1: b[0] = v[7:0];
            2: begin b[0] = 8'hC0 | {2'b00, v[13:8]}; b[1] = v[7:0]; end
            3: begin b[0] = 8'hF0 | {4'h0, v[19:16]}; b[1] = v[15:8]; b[2] = v[7:0]; end
            4: begin b[0] = 8'hFC | {6'h0, v[25:24]}; b[1] = v[23:16];
                     b[2] = v[15:8]; b[3] = v[7:0]; end
            default: begin b[0] = 8'hFF; b[1] = v[31:24]; b[2] = v[23:16];
                           b[3] = v[15:8]; b[4] = v[7:0]; end
        endcase
        e.v   = v;
        e.len = 3'(n);
        e.ovl = (v < limit_for(n));
        exp_q.push_back(e);
        for (int i = 0; i < n; i++) send_byte(b[i], gap);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "ready in reset", 32'(in_ready), 32'h1);
        chk(out_done == 1'b0, "R1", "done in reset", 32'(out_done), 32'h0);
        chk(out_trunc == 1'b0, "R1", "trunc in reset", 32'(out_trunc), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_overlong == 1'b0, "R1", "idle after reset",
            32'({in_ready, out_overlong}), 32'h2);

        // R2 one-byte forms, back to back (R7)
        send_op(1, 32'h00, 1'b0);
        send_op(1, 32'h7F, 1'b0);
        send_op(1, 32'hBF, 1'b0);
        // R3 two-byte forms, R8 boundary
        send_op(2, 32'h00C0, 1'b0);
        send_op(2, 32'h2FFF, 1'b0);
        send_op(2, 32'h00BF, 1'b0);
        send_op(2, 32'h0005, 1'b0);
        // R4 three-byte forms
        send_op(3, 32'h12345, 1'b0);
        send_op(3, 32'hBFFFF, 1'b0);
        send_op(3, 32'h02FFF, 1'b0);
        send_op(3, 32'h03000, 1'b0);
        // R5 four-byte forms
        send_op(4, 32'h1ABCDEF, 1'b0);
        send_op(4, 32'h2FFFFFF, 1'b0);
        send_op(4, 32'h00BFFFF, 1'b0);
        send_op(4, 32'h00C0000, 1'b0);
        // R6 five-byte forms
        send_op(5, 32'hDEADBEEF, 1'b0);
        send_op(5, 32'h03000000, 1'b0);
        send_op(5, 32'h02FFFFFF, 1'b0);
        send_op(5, 32'h00000000, 1'b0);
        send_op(1, 32'h41, 1'b0);
        // R10 gaps between bytes
        send_op(5, 32'hCAFE0123, 1'b1);
        send_op(2, 32'h1234, 1'b1);
        send_op(1, 32'h3C, 1'b1);
        repeat (3) @(negedge clk);

        // R9 flush mid-opcode
        send_byte(8'hF1, 1'b0);
        send_byte(8'h22, 1'b0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(out_trunc == 1'b1, "R9", "trunc pulse", 32'(out_trunc), 32'h1);
        chk(out_done == 1'b0, "R9", "no done on flush", 32'(out_done), 32'h0);
        @(negedge clk);
        chk(out_trunc == 1'b0, "R9", "trunc one cycle", 32'(out_trunc), 32'h0);
        send_op(1, 32'h41, 1'b0);
        send_op(4, 32'h0123456, 1'b0);

        // R9 flush right after a five-byte first byte
        send_byte(8'hFF, 1'b0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(out_trunc == 1'b1, "R9", "trunc after one byte", 32'(out_trunc), 32'h1);
        send_op(2, 32'h0ABC, 1'b0);
        repeat (2) @(negedge clk);

        // R9 flush while waiting for a first byte has no effect
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(out_trunc == 1'b0 && in_ready == 1'b1, "R9", "idle flush ignored",
            32'({out_trunc, in_ready}), 32'h1);
        send_op(3, 32'h54321, 1'b0);

        // R1 reset mid-opcode
        send_byte(8'hFF, 1'b0);
        send_byte(8'h11, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1 && out_done == 1'b0, "R1", "reset drops partial",
            32'({in_ready, out_done}), 32'h2);
        send_op(1, 32'h33, 1'b0);
        send_op(2, 32'h0100, 1'b0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "results outstanding", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule